// File: doc/BRIEF.md
# Banked Sensor Channel Limit Monitor

This block watches a small set of measurement channels that share one register window. A bank-select register chooses which channel the per-channel registers address: an enable/status register, a read-only latest reading, and three signed thresholds (upper window bound, lower window bound, and an over-limit trip point). Converted samples arrive on a valid/channel/data input. Every accepted sample is stored as the channel's reading and compared against that channel's thresholds in the same cycle.

Crossings are latched as sticky event bits in a global status register, which software clears by writing ones. Two mask registers route the latched events to a system-management interrupt line and a regular interrupt line. A third output, independent of both masks, stays high while any over-limit event is latched. A global configuration register gives software a byte of storage. The block does no analog conversion and no unit scaling.

Top module: `chan_limit_mon`

## Requirements
- R1: After reset, status, both masks, global configuration, bank select, channel enables and readings are 0. Every channel's upper bound and over-limit threshold is 0x7F and its lower bound is 0x80. All three interrupt outputs are low.
- R2: Bank select at offset 0x9 reads back the full byte written. Offsets 0xA, 0xB, 0xC, 0xD and 0xE address the channel whose number equals the bank select value. 0xC is the upper bound, 0xD the lower bound and 0xE the over-limit threshold, all read/write.
- R3: Bit 0 of offset 0xA is the selected channel's enable. The offset reads back as {7'b0, enable}.
- R4: A sample whose channel is enabled replaces that channel's reading at offset 0xB, one clock after it is presented. A sample for a disabled channel, or for a channel number at or above the channel count, is dropped: the reading and the status stay unchanged.
- R5: An accepted sample on channel c sets status bit c (offset 0x0) if it is greater than the upper bound or less than the lower bound. All comparisons are two's-complement signed.
- R6: An accepted sample on channel c sets status bit c+4 if it is greater than or equal to the over-limit threshold, using a signed comparison.
- R7: Writing offset 0x0 clears every status bit written as 1. An event raised in the same cycle wins over the clear.
- R8: smiOut is the OR of status AND the mask at offset 0x2. irqOut is the OR of status AND the mask at offset 0x4.
- R9: overLimit is high while any of status bits 4 to 7 is set, whatever the masks hold.
- R10: While bank select is 3 or more, offsets 0xA to 0xE read 0 and writes to them change nothing.
- R11: Offset 0x8 is a read/write byte. Writes to offset 0xB are ignored. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register offset for read and write |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data for regAddr |
| smpValid | input | 1 | Sample present |
| smpChan | input | 2 | Channel number of the sample |
| smpData | input | 8 | Signed sample value |
| smiOut | output | 1 | Masked event line to system management |
| irqOut | output | 1 | Masked event line to the interrupt controller |
| overLimit | output | 1 | Any over-limit event latched |

## Verification
The bench aims at the signed compares. A sample of 0xC0 lies below a lower bound of 0 but stays under an over-limit threshold of 0x30. A design that compared unsigned would also raise the over-limit bit and would wrongly assert overLimit. It clears a status bit while the same channel raises it again; a design that lets the clear win would lose the event and drop smiOut. It sends samples to disabled and nonexistent channels and writes through a bank select of 3. A design that did not guard these would corrupt readings or limits, which the bench sees when it reads them back. A cycle-accurate reference model also checks every output and the read port on each clock.

// File: rtl/clm_pkg.sv
package clm_pkg;
  localparam int MAX_CHAN = 4;
  localparam int CIDX_W   = 2;
  localparam int REG_W    = 8;

  typedef enum logic [3:0] {
    ADDR_STATUS = 4'h0,
    ADDR_SMI    = 4'h2,
    ADDR_IRQ    = 4'h4,
    ADDR_GLOBAL = 4'h8,
    ADDR_BANK   = 4'h9,
    ADDR_CFG    = 4'hA,
    ADDR_READ   = 4'hB,
    ADDR_HIGH   = 4'hC,
    ADDR_LOW    = 4'hD,
    ADDR_OVER   = 4'hE
  } regAddrE;

  typedef struct packed {
    logic wrStatus;
    logic wrSmi;
    logic wrIrq;
    logic wrGlobal;
    logic wrBank;
    logic wrCfg;
    logic wrHigh;
    logic wrLow;
    logic wrOver;
    logic chanOk;
    logic [CIDX_W-1:0] chanSel;
    logic smpTake;
  } strobeT;
endpackage

// File: rtl/clm_ctrl.sv
module clm_ctrl
  import clm_pkg::*;
#(
  parameter int NUM_CHAN = 3
) (
  input  logic                regWrEn,
  input  logic [3:0]          regAddr,
  input  logic [REG_W-1:0]    bankSel,
  input  logic                smpValid,
  input  logic [CIDX_W-1:0]   smpChan,
  input  logic [NUM_CHAN-1:0] chanEn,
  output strobeT              st
);
  logic chanOk;
  logic take;

  assign chanOk = bankSel < REG_W'(NUM_CHAN);

  always_comb begin
    take = 1'b0;
    for (int c = 0; c < NUM_CHAN; c++) begin
      if (smpChan == CIDX_W'(c) && chanEn[c]) take = 1'b1;
    end
  end

  always_comb begin
    st          = '0;
    st.chanOk   = chanOk;
    st.chanSel  = bankSel[CIDX_W-1:0];
    st.smpTake  = smpValid && take;
    st.wrStatus = regWrEn && regAddr == ADDR_STATUS;
    st.wrSmi    = regWrEn && regAddr == ADDR_SMI;
    st.wrIrq    = regWrEn && regAddr == ADDR_IRQ;
    st.wrGlobal = regWrEn && regAddr == ADDR_GLOBAL;
    st.wrBank   = regWrEn && regAddr == ADDR_BANK;
    st.wrCfg    = regWrEn && regAddr == ADDR_CFG  && chanOk;
    st.wrHigh   = regWrEn && regAddr == ADDR_HIGH && chanOk;
    st.wrLow    = regWrEn && regAddr == ADDR_LOW  && chanOk;
    st.wrOver   = regWrEn && regAddr == ADDR_OVER && chanOk;
  end
endmodule

// File: rtl/clm_datapath.sv
module clm_datapath
  import clm_pkg::*;
#(
  parameter int          NUM_CHAN = 3,
  parameter logic [7:0]  HIGH_RST = 8'h7F,
  parameter logic [7:0]  LOW_RST  = 8'h80,
  parameter logic [7:0]  OVER_RST = 8'h7F
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobeT                st,
  input  logic [3:0]            regAddr,
  input  logic [REG_W-1:0]      regWrData,
  input  logic [CIDX_W-1:0]     smpChan,
  input  logic [REG_W-1:0]      smpData,
  output logic [REG_W-1:0]      regRdData,
  output logic [REG_W-1:0]      bankSel,
  output logic [NUM_CHAN-1:0]   chanEn,
  output logic [2*MAX_CHAN-1:0] evtStatus,
  output logic [REG_W-1:0]      smiMask,
  output logic [REG_W-1:0]      irqMask
);
  localparam int ST_W = 2 * MAX_CHAN;

  logic [REG_W-1:0]        globalCfg;
  logic signed [REG_W-1:0] readReg [NUM_CHAN];
  logic signed [REG_W-1:0] highReg [NUM_CHAN];
  logic signed [REG_W-1:0] lowReg  [NUM_CHAN];
  logic signed [REG_W-1:0] overReg [NUM_CHAN];
  logic signed [REG_W-1:0] sSmp;
  logic [NUM_CHAN-1:0]     winEvt;
  logic [NUM_CHAN-1:0]     ovrEvt;
  logic [ST_W-1:0]         newEvt;
  logic [ST_W-1:0]         clrMask;

  assign sSmp = smpData;

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_cmp
    logic hit;
    assign hit       = st.smpTake && smpChan == CIDX_W'(c);
    assign winEvt[c] = hit && (sSmp > highReg[c] || sSmp < lowReg[c]);
    assign ovrEvt[c] = hit && (sSmp >= overReg[c]);
  end

  always_comb begin
    newEvt = '0;
    for (int c = 0; c < NUM_CHAN; c++) begin
      newEvt[c]            = winEvt[c];
      newEvt[c + MAX_CHAN] = ovrEvt[c];
    end
  end

  assign clrMask = st.wrStatus ? regWrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtStatus <= '0;
      smiMask   <= '0;
      irqMask   <= '0;
      globalCfg <= '0;
      bankSel   <= '0;
    end else begin
      evtStatus <= (evtStatus & ~clrMask) | newEvt;
      if (st.wrSmi)    smiMask   <= regWrData;
      if (st.wrIrq)    irqMask   <= regWrData;
      if (st.wrGlobal) globalCfg <= regWrData;
      if (st.wrBank)   bankSel   <= regWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CHAN; c++) begin
        chanEn[c]  <= 1'b0;
        readReg[c] <= '0;
        highReg[c] <= HIGH_RST;
        lowReg[c]  <= LOW_RST;
        overReg[c] <= OVER_RST;
      end
    end else begin
      for (int c = 0; c < NUM_CHAN; c++) begin
        if (st.chanSel == CIDX_W'(c)) begin
          if (st.wrCfg)  chanEn[c]  <= regWrData[0];
          if (st.wrHigh) highReg[c] <= regWrData;
          if (st.wrLow)  lowReg[c]  <= regWrData;
          if (st.wrOver) overReg[c] <= regWrData;
        end
        if (st.smpTake && smpChan == CIDX_W'(c)) readReg[c] <= sSmp;
      end
    end
  end

  logic             selEn;
  logic [REG_W-1:0] selRead, selHigh, selLow, selOver;

  always_comb begin
    selEn   = 1'b0;
    selRead = '0;
    selHigh = '0;
    selLow  = '0;
    selOver = '0;
    for (int c = 0; c < NUM_CHAN; c++) begin
      if (st.chanOk && st.chanSel == CIDX_W'(c)) begin
        selEn   = chanEn[c];
        selRead = readReg[c];
        selHigh = highReg[c];
        selLow  = lowReg[c];
        selOver = overReg[c];
      end
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_STATUS: regRdData = evtStatus;
      ADDR_SMI:    regRdData = smiMask;
      ADDR_IRQ:    regRdData = irqMask;
      ADDR_GLOBAL: regRdData = globalCfg;
      ADDR_BANK:   regRdData = bankSel;
      ADDR_CFG:    regRdData = {{(REG_W-1){1'b0}}, selEn};
      ADDR_READ:   regRdData = selRead;
      ADDR_HIGH:   regRdData = selHigh;
      ADDR_LOW:    regRdData = selLow;
      ADDR_OVER:   regRdData = selOver;
      default:     regRdData = '0;
    endcase
  end
endmodule

// File: rtl/chan_limit_mon.sv
module chan_limit_mon
  import clm_pkg::*;
#(
  parameter int NUM_CHAN = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [3:0]        regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              smpValid,
  input  logic [CIDX_W-1:0] smpChan,
  input  logic [REG_W-1:0]  smpData,
  output logic              smiOut,
  output logic              irqOut,
  output logic              overLimit
);
  strobeT                st;
  logic [REG_W-1:0]      bankSel;
  logic [NUM_CHAN-1:0]   chanEn;
  logic [2*MAX_CHAN-1:0] evtStatus;
  logic [REG_W-1:0]      smiMask;
  logic [REG_W-1:0]      irqMask;

  clm_ctrl #(.NUM_CHAN(NUM_CHAN)) u_ctrl (
    .regWrEn(regWrEn), .regAddr(regAddr), .bankSel(bankSel),
    .smpValid(smpValid), .smpChan(smpChan), .chanEn(chanEn), .st(st)
  );

  clm_datapath #(.NUM_CHAN(NUM_CHAN)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .regAddr(regAddr),
    .regWrData(regWrData), .smpChan(smpChan), .smpData(smpData),
    .regRdData(regRdData), .bankSel(bankSel), .chanEn(chanEn),
    .evtStatus(evtStatus), .smiMask(smiMask), .irqMask(irqMask)
  );

  assign smiOut    = |(evtStatus & smiMask);
  assign irqOut    = |(evtStatus & irqMask);
  assign overLimit = |evtStatus[2*MAX_CHAN-1:MAX_CHAN];
endmodule

// File: rtl/clm_checker.sv
module clm_checker #(
  parameter int NUM_CHAN = 3
) (
  input logic       clk,
  input logic       rstN,
  input logic       regWrEn,
  input logic [3:0] regAddr,
  input logic [7:0] regWrData,
  input logic [7:0] regRdData,
  input logic       smpValid,
  input logic       smiOut,
  input logic       irqOut,
  input logic       overLimit,
  input logic [7:0] evtStatus,
  input logic [7:0] smiMask,
  input logic [7:0] irqMask,
  input logic [7:0] bankSel
);
  assert_new_event_needs_sample_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((evtStatus & ~$past(evtStatus)) != 8'h0) |-> $past(smpValid));

  assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 4'h0 && !smpValid) |=> ((evtStatus & $past(regWrData)) == 8'h0));

  assert_smi_masked_R8: assert property (@(posedge clk) disable iff (!rstN)
    (smiMask == 8'h0) |-> !smiOut);

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rstN)
    (irqMask == 8'h0) |-> !irqOut);

  assert_overlimit_rise_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overLimit) |-> $past(smpValid));

  assert_bank_empty_reads_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr >= 4'hA && regAddr <= 4'hE && bankSel >= 8'(NUM_CHAN)) |-> (regRdData == 8'h0));
endmodule

bind chan_limit_mon clm_checker #(.NUM_CHAN(NUM_CHAN)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .regRdData(regRdData), .smpValid(smpValid),
  .smiOut(smiOut), .irqOut(irqOut), .overLimit(overLimit),
  .evtStatus(evtStatus), .smiMask(smiMask), .irqMask(irqMask), .bankSel(bankSel)
);

// File: tb/tb_chan_limit_mon.sv
module tb_chan_limit_mon;
  localparam int NCH = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [3:0] regAddr = 4'h0;
  logic [7:0] regWrData = 8'h0;
  logic [7:0] regRdData;
  logic       smpValid = 1'b0;
  logic [1:0] smpChan = 2'd0;
  logic [7:0] smpData = 8'h0;
  logic       smiOut, irqOut, overLimit;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  chan_limit_mon #(.NUM_CHAN(NCH)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .smpValid(smpValid),
    .smpChan(smpChan), .smpData(smpData), .smiOut(smiOut),
    .irqOut(irqOut), .overLimit(overLimit)
  );

  // behavioural reference model
  byte mRead[NCH], mHigh[NCH], mLow[NCH], mOver[NCH];
  bit  mEn[NCH];
  logic [7:0] mStat, mSmi, mIrq, mGlob, mBank;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mStat = 0; mSmi = 0; mIrq = 0; mGlob = 0; mBank = 0;
      for (int c = 0; c < NCH; c++) begin
        mEn[c] = 0; mRead[c] = 0; mHigh[c] = 8'sh7F; mLow[c] = -8'sd128; mOver[c] = 8'sh7F;
      end
    end else begin
      logic [7:0] ev;
      logic [7:0] clr;
      ev = 0; clr = 0;
      if (smpValid && int'(smpChan) < NCH && mEn[smpChan]) begin
        byte d;
        d = $signed(smpData);
        if (d > mHigh[smpChan] || d < mLow[smpChan]) ev[smpChan] = 1'b1;
        if (d >= mOver[smpChan]) ev[int'(smpChan) + 4] = 1'b1;
        mRead[smpChan] = d;
      end
      if (regWrEn) begin
        case (regAddr)
          4'h0: clr = regWrData;
          4'h2: mSmi = regWrData;
          4'h4: mIrq = regWrData;
          4'h8: mGlob = regWrData;
          4'h9: mBank = regWrData;
          default: if (int'(mBank) < NCH) begin
            case (regAddr)
              4'hA: mEn[mBank] = regWrData[0];
              4'hC: mHigh[mBank] = $signed(regWrData);
              4'hD: mLow[mBank] = $signed(regWrData);
              4'hE: mOver[mBank] = $signed(regWrData);
              default: ;
            endcase
          end
        endcase
      end
      mStat = (mStat & ~clr) | ev;
    end
  end

  function automatic logic [7:0] mdlRead(input logic [3:0] a);
    bit ok;
    ok = int'(mBank) < NCH;
    case (a)
      4'h0: return mStat;
      4'h2: return mSmi;
      4'h4: return mIrq;
      4'h8: return mGlob;
      4'h9: return mBank;
      4'hA: return ok ? {7'b0, mEn[mBank]} : 8'h0;
      4'hB: return ok ? mRead[mBank] : 8'h0;
      4'hC: return ok ? mHigh[mBank] : 8'h0;
      4'hD: return ok ? mLow[mBank] : 8'h0;
      4'hE: return ok ? mOver[mBank] : 8'h0;
      default: return 8'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    if (rstN) begin
      #1;
      chk("R2 model read port", regRdData, mdlRead(regAddr));
      chk("R8 model smiOut", {7'b0, smiOut}, {7'b0, |(mStat & mSmi)});
      chk("R8 model irqOut", {7'b0, irqOut}, {7'b0, |(mStat & mIrq)});
      chk("R9 model overLimit", {7'b0, overLimit}, {7'b0, |mStat[7:4]});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic smp(input logic [1:0] c, input logic [7:0] d);
    @(negedge clk);
    smpValid = 1'b1; smpChan = c; smpData = d;
    @(negedge clk);
    smpValid = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    regWrEn = 1'b0; regAddr = a;
    #1;
    chk(tag, regRdData, exp);
  endtask

  task automatic outs(input bit s, input bit i, input bit o, input string tag);
    @(negedge clk);
    #1;
    chk(tag, {5'b0, smiOut, irqOut, overLimit}, {5'b0, s, i, o});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset values
    rd(4'h0, 8'h00, "R1 status reset");
    rd(4'hC, 8'h7F, "R1 upper bound reset");
    rd(4'hD, 8'h80, "R1 lower bound reset");
    rd(4'hE, 8'h7F, "R1 over threshold reset");
    rd(4'hB, 8'h00, "R1 reading reset");
    outs(0, 0, 0, "R1 outputs reset");
    // channel 0: upper 0x20, lower -16
    wr(4'hA, 8'h01);
    wr(4'hC, 8'h20);
    wr(4'hD, 8'hF0);
    rd(4'hA, 8'h01, "R3 enable readback");
    // channel 1: upper 0x10, lower 0, over 0x30
    wr(4'h9, 8'h01);
    rd(4'h9, 8'h01, "R2 bank readback");
    wr(4'hA, 8'h01);
    wr(4'hC, 8'h10);
    wr(4'hD, 8'h00);
    wr(4'hE, 8'h30);
    rd(4'hC, 8'h10, "R2 bank1 upper bound");
    wr(4'h9, 8'h00);
    rd(4'hC, 8'h20, "R2 bank0 upper bound kept");
    // in-window sample
    smp(2'd0, 8'h10);
    rd(4'hB, 8'h10, "R4 reading updated");
    rd(4'h0, 8'h00, "R5 in-window no event");
    smp(2'd0, 8'h21);
    rd(4'h0, 8'h01, "R5 above upper bound");
    smp(2'd1, 8'hFF);
    rd(4'h0, 8'h03, "R5 signed below lower bound");
    outs(0, 0, 0, "R9 no over event yet");
    smp(2'd1, 8'h30);
    rd(4'h0, 8'h23, "R6 reaches over threshold");
    outs(0, 0, 1, "R9 overLimit with masks clear");
    // disabled and nonexistent channels
    wr(4'h9, 8'h02);
    rd(4'hA, 8'h00, "R3 bank2 disabled");
    smp(2'd2, 8'h7F);
    rd(4'hB, 8'h00, "R4 disabled sample dropped");
    smp(2'd3, 8'h7F);
    rd(4'h0, 8'h23, "R4 status unchanged after drops");
    // masks
    wr(4'h2, 8'h01);
    wr(4'h4, 8'h20);
    outs(1, 1, 1, "R8 masked outputs");
    wr(4'h0, 8'h20);
    rd(4'h0, 8'h03, "R7 write one clears");
    outs(1, 0, 0, "R7 irq falls after clear");
    // clear and raise together
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 4'h0; regWrData = 8'h01;
    smpValid = 1'b1; smpChan = 2'd0; smpData = 8'h50;
    @(negedge clk);
    regWrEn = 1'b0; smpValid = 1'b0;
    rd(4'h0, 8'h03, "R7 set wins over clear");
    outs(1, 0, 0, "R7 smi stays");
    // signed over-limit: 0xC0 is below lower bound but not over 0x30
    wr(4'h0, 8'hFF);
    smp(2'd1, 8'hC0);
    rd(4'h0, 8'h02, "R6 signed over compare");
    outs(0, 0, 0, "R6 no overLimit for negative");
    // empty bank
    wr(4'h9, 8'h03);
    rd(4'hC, 8'h00, "R10 empty bank reads zero");
    rd(4'hA, 8'h00, "R10 empty bank cfg zero");
    wr(4'hC, 8'h11);
    wr(4'hA, 8'h00);
    wr(4'h9, 8'h00);
    rd(4'hC, 8'h20, "R10 empty bank write ignored");
    rd(4'hA, 8'h01, "R10 enable untouched");
    // misc registers
    wr(4'hB, 8'h77);
    rd(4'hB, 8'h50, "R11 reading write ignored");
    wr(4'h8, 8'h5A);
    rd(4'h8, 8'h5A, "R11 global config readback");
    rd(4'h1, 8'h00, "R11 unmapped offset");
    // disable channel 0, sample dropped
    wr(4'hA, 8'h00);
    smp(2'd0, 8'h05);
    rd(4'hB, 8'h50, "R4 disabled channel keeps reading");
    repeat (4) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule